// File: doc/BRIEF.md
# Cache Line Burst Fill Controller

This block is the bus-master side of a cache line refill. A cache miss hands it a longword address, a function code and the cache state. It then runs a read on a 32-bit synchronous port. The fill is four longwords when the slave agrees to burst, and one longword when it does not. Every longword the port terminates is passed to the cache with its position in the line. A separate strobe tells the cache when the line is complete, and another tells it to throw away a partial line.

While a read is running, the address, function code, direction and size outputs are frozen and the strobes stay asserted. For arbitration and halting, the whole burst therefore counts as one bus cycle. A synchronized halt request or bus request from another master is only honoured when no read is in progress. A read ends early in three cases: the slave marks the data non-cacheable, a bus error arrives, or the slave withdraws its burst acknowledge before the line is full.

Top module: `line_burst_fill`

## Requirements
- R1: After reset the strobes, the burst request, every pulse output, `halted` and `bus_grant` are low.
- R2: A miss accepted in the idle state asserts `bus_as` and `bus_ds` on the next cycle. `burst_req` is raised together with them only when `cache_enable` is 1, `cache_frozen` is 0 and `rmw_cycle` is 0. `burst_req` is never high while `bus_as` is low.
- R3: While `bus_as` is high, `bus_addr` equals the miss address, `bus_fc` equals the miss function code, `bus_rw` is 1 (read) and `bus_size` is 2'b00 (longword). None of them changes until the read ends.
- R4: The read continues as a burst only if the first `sync_term` cycle comes with `burst_ack` high while `burst_req` is high. Otherwise that single transfer ends the read, with no `line_done`.
- R5: Each cycle with `sync_term` high, no inhibit and no synchronized bus error accepts one longword. `word_we` pulses with `word_data` equal to `bus_data`. `word_idx` starts at miss address bits [3:2] and adds one per word, modulo 4. The fourth word of a burst also pulses `line_done`, and the read then ends.
- R6: `burst_req` stays high through the third accepted word and is low from the next cycle on, including the fourth transfer and its wait states.
- R7: `cache_inhibit` high during a read pulses `line_drop` for one cycle, accepts no word in that cycle, gives no `line_done`, and ends the read on the next cycle.
- R8: `bus_err_in` passes through a two-stage synchronizer. A synchronized error during a read gives a one-cycle `err_pulse`, accepts no word, takes priority over `cache_inhibit`, and returns the controller to idle.
- R9: `burst_ack` low on the second or third word of a burst accepts that word and ends the read without `line_done`. `burst_ack` is ignored on the fourth word.
- R10: A halt request raised during a read takes effect only after the read ends. `halted` stays high while the synchronized halt is high, and no miss is started during that time.
- R11: `bus_grant` is given only outside a read, on a synchronized bus request, with halt taking priority. No miss is started while the grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| miss_req | input | 1 | Cache miss, start a fill |
| miss_addr | input | AW | Miss address |
| miss_fc | input | 3 | Function code of the miss |
| cache_enable | input | 1 | Target cache enabled |
| cache_frozen | input | 1 | Target cache frozen |
| rmw_cycle | input | 1 | Access belongs to a read-modify-write |
| bus_addr | output | AW | Bus address |
| bus_fc | output | 3 | Bus function code |
| bus_size | output | 2 | Transfer size, 2'b00 = longword |
| bus_rw | output | 1 | 1 = read |
| bus_as | output | 1 | Address strobe |
| bus_ds | output | 1 | Data strobe |
| burst_req | output | 1 | Burst request to slave |
| sync_term | input | 1 | Synchronous termination |
| burst_ack | input | 1 | Burst acknowledge |
| cache_inhibit | input | 1 | Slave marks data non-cacheable |
| bus_data | input | DW | Read data |
| bus_err_in | input | 1 | Bus error, asynchronous |
| halt_in | input | 1 | Halt request, asynchronous |
| breq_in | input | 1 | Bus request from another master, asynchronous |
| word_we | output | 1 | Longword accepted for the cache |
| word_idx | output | 2 | Longword position in the line |
| word_data | output | DW | Accepted longword |
| line_done | output | 1 | Line complete, mark valid |
| line_drop | output | 1 | Discard partial line |
| err_pulse | output | 1 | Bus error abort |
| halted | output | 1 | Controller halted |
| bus_grant | output | 1 | Bus granted to another master |

## Verification
Two collisions matter. The first is a halt and a foreign bus request that both arrive while a burst is running. Both are raised before a full fill; at the end of the burst `halted` must rise and `bus_grant` must stay low, and the grant may appear only after the halt is released. The second is a bus error that ripens out of the synchronizer in the same cycle as a terminated transfer with `cache_inhibit` high. There `err_pulse` must win, with neither `line_drop` nor `word_we`.

// File: rtl/line_burst_fill.sv
module line_burst_fill #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_req,
  input  logic [AW-1:0] miss_addr,
  input  logic [2:0]    miss_fc,
  input  logic          cache_enable,
  input  logic          cache_frozen,
  input  logic          rmw_cycle,
  output logic [AW-1:0] bus_addr,
  output logic [2:0]    bus_fc,
  output logic [1:0]    bus_size,
  output logic          bus_rw,
  output logic          bus_as,
  output logic          bus_ds,
  output logic          burst_req,
  input  logic          sync_term,
  input  logic          burst_ack,
  input  logic          cache_inhibit,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_err_in,
  input  logic          halt_in,
  input  logic          breq_in,
  output logic          word_we,
  output logic [1:0]    word_idx,
  output logic [DW-1:0] word_data,
  output logic          line_done,
  output logic          line_drop,
  output logic          err_pulse,
  output logic          halted,
  output logic          bus_grant
);

  localparam logic [1:0] LAST_WORD = 2'd3;
  localparam logic [1:0] REQ_DROP_WORD = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_HALT, S_GRANT} state_t;

  state_t st, st_after;
  logic [AW-1:0] addr_q;
  logic [2:0] fc_q;
  logic [1:0] idx_q, cnt_q;
  logic req_q;
  logic [SYNC_STAGES-1:0] err_sh, halt_sh, breq_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      err_sh  <= '0;
      halt_sh <= '0;
      breq_sh <= '0;
    end else begin
      err_sh  <= {err_sh[SYNC_STAGES-2:0], bus_err_in};
      halt_sh <= {halt_sh[SYNC_STAGES-2:0], halt_in};
      breq_sh <= {breq_sh[SYNC_STAGES-2:0], breq_in};
    end

  wire err_s  = err_sh[SYNC_STAGES-1];
  wire halt_s = halt_sh[SYNC_STAGES-1];
  wire breq_s = breq_sh[SYNC_STAGES-1];

  wire active = (st == S_XFER);
  wire allow  = cache_enable && !cache_frozen && !rmw_cycle;

  assign bus_addr  = addr_q;
  assign bus_fc    = fc_q;
  assign bus_size  = 2'b00;
  assign bus_rw    = 1'b1;
  assign bus_as    = active;
  assign bus_ds    = active;
  assign burst_req = active && req_q;
  assign halted    = (st == S_HALT);
  assign bus_grant = (st == S_GRANT);

  assign err_pulse = active && err_s;
  assign line_drop = active && !err_s && cache_inhibit;
  assign word_we   = active && sync_term && !err_s && !cache_inhibit;
  assign word_idx  = idx_q;
  assign word_data = bus_data;
  assign line_done = word_we && (cnt_q == LAST_WORD);

  wire xfer_end = err_pulse || line_drop || (word_we && !(req_q && burst_ack));

  always_comb begin
    if (halt_s)      st_after = S_HALT;
    else if (breq_s) st_after = S_GRANT;
    else             st_after = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      fc_q   <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      req_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (halt_s || breq_s) st <= st_after;
          else if (miss_req) begin
            st     <= S_XFER;
            addr_q <= miss_addr;
            fc_q   <= miss_fc;
            idx_q  <= miss_addr[3:2];
            cnt_q  <= '0;
            req_q  <= allow;
          end
        S_XFER:
          if (xfer_end) begin
            st    <= st_after;
            req_q <= 1'b0;
          end else if (word_we) begin
            idx_q <= idx_q + 2'd1;
            cnt_q <= cnt_q + 2'd1;
            if (cnt_q == REQ_DROP_WORD) req_q <= 1'b0;
          end
        S_HALT:  if (!halt_s) st <= S_IDLE;
        default: if (!breq_s) st <= S_IDLE;
      endcase
    end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as && $past(bus_as) |-> $stable(bus_addr) && $stable(bus_fc)); // R3
  AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) && !halt_s && !breq_s && miss_req && !allow |=> bus_as && !burst_req); // R2
  AST_REQ_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |-> bus_as); // R2
  AST_REQ_DROP_THIRD: assert property (@(posedge clk) disable iff (!rst_n)
    word_we && (cnt_q == REQ_DROP_WORD) |=> !burst_req); // R6
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !bus_as); // R5
  AST_DROP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    line_drop |=> !bus_as && !line_drop); // R7
  AST_ERR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse && !bus_as); // R8
  AST_HALT_SYNCED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(halt_s) && !$past(bus_as && !xfer_end)); // R10
  AST_GRANT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_grant) |-> $past(breq_s) && !$past(halt_s)); // R11

endmodule

// File: tb/test_line_burst_fill.sv
module test_line_burst_fill;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_req = 0, cache_enable = 0, cache_frozen = 0, rmw_cycle = 0;
  logic [31:0] miss_addr = '0;
  logic [2:0] miss_fc = '0;
  logic sync_term = 0, burst_ack = 0, cache_inhibit = 0;
  logic [31:0] bus_data = '0;
  logic bus_err_in = 0, halt_in = 0, breq_in = 0;
  logic [31:0] bus_addr, word_data;
  logic [2:0] bus_fc;
  logic [1:0] bus_size, word_idx;
  logic bus_rw, bus_as, bus_ds, burst_req, word_we, line_done, line_drop, err_pulse, halted, bus_grant;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  line_burst_fill i_line_burst_fill (
    .clk, .rst_n, .miss_req, .miss_addr, .miss_fc, .cache_enable, .cache_frozen, .rmw_cycle,
    .bus_addr, .bus_fc, .bus_size, .bus_rw, .bus_as, .bus_ds, .burst_req,
    .sync_term, .burst_ack, .cache_inhibit, .bus_data, .bus_err_in, .halt_in, .breq_in,
    .word_we, .word_idx, .word_data, .line_done, .line_drop, .err_pulse, .halted, .bus_grant);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic start_miss(input logic [31:0] a, input logic [2:0] cfg);
    @(negedge clk);
    miss_req = 1; miss_addr = a; miss_fc = cfg;
    cache_enable = cfg[0]; cache_frozen = cfg[1]; rmw_cycle = cfg[2];
    @(negedge clk);
    miss_req = 0; miss_addr = ~a; miss_fc = ~cfg;
  endtask

  task automatic held_chk(input logic [31:0] a, input logic [2:0] cfg);
    chk(bus_as && bus_ds, "R2 strobes", {bus_as, bus_ds}, 2'b11);
    chk(bus_addr == a && bus_fc == cfg && bus_rw && bus_size == 2'b00, "R3 held",
        {bus_addr, bus_fc, bus_rw, bus_size}, {a, cfg, 1'b1, 2'b00});
  endtask

  task automatic do_fill(input logic [31:0] a, input logic [2:0] cfg, input int ackd, input int wt);
    bit allow = cfg[0] && !cfg[1] && !cfg[2];
    start_miss(a, cfg);
    for (int k = 0; k < 4; k++) begin
      for (int w = 0; w < wt; w++) begin
        sync_term = 0; burst_ack = 1;
        #1;
        held_chk(a, cfg);
        chk(!word_we, "R5 wait no word", word_we, 0);
        chk(burst_req == (allow && k < 3), "R6 req in wait", burst_req, allow && k < 3);
        @(negedge clk);
      end
      sync_term = 1; burst_ack = (k != ackd); bus_data = a + 32'(k) * 32'h1111;
      #1;
      held_chk(a, cfg);
      chk(burst_req == (allow && k < 3), "R6 req", burst_req, allow && k < 3);
      chk(word_we && word_data == a + 32'(k) * 32'h1111, "R5 word", word_data, a + 32'(k) * 32'h1111);
      chk(word_idx == 2'(a[3:2] + k), "R5 index", word_idx, 2'(a[3:2] + k));
      chk(line_done == (k == 3), "R5 line done", line_done, k == 3);
      chk(!halted && !bus_grant, "R10 R11 deferred", {halted, bus_grant}, 0);
      @(negedge clk);
      sync_term = 0; burst_ack = 0;
      if (!(allow && k != ackd && k < 3)) break;
    end
    #1 chk(!bus_as && !burst_req, "R4 R9 read ended", bus_as, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!bus_as && !bus_ds && !burst_req && !word_we && !line_done && !line_drop && !err_pulse && !halted && !bus_grant,
        "R1 reset", {bus_as, burst_req, err_pulse, halted, bus_grant}, 0);
    rst_n = 1;

    for (int a = 0; a < 4; a++)
      for (int cfg = 0; cfg < 8; cfg++)
        for (int ackd = 0; ackd < 5; ackd++)
          do_fill(32'h4000_1000 + 32'(a) * 4 + 32'(cfg) * 32'h100, 3'(cfg), ackd, (a + ackd) % 3);

    for (int at = 0; at < 4; at++) begin
      start_miss(32'h8000_0020 + 32'(at) * 4, 3'b001);
      for (int k = 0; k < at; k++) begin sync_term = 1; burst_ack = 1; @(negedge clk); end
      sync_term = 1; cache_inhibit = 1;
      #1;
      chk(line_drop && !word_we && !line_done, "R7 inhibit", {line_drop, word_we, line_done}, 3'b100);
      @(negedge clk);
      sync_term = 0; cache_inhibit = 0;
      #1 chk(!bus_as && !line_drop, "R7 ended", {bus_as, line_drop}, 0);
    end

    for (int at = 0; at < 4; at++) begin
      start_miss(32'h9000_0000 + 32'(at) * 4, 3'b001);
      for (int k = 0; k < at; k++) begin sync_term = 1; burst_ack = 1; @(negedge clk); end
      sync_term = 0; bus_err_in = 1;
      #1 chk(!err_pulse, "R8 sync delay", err_pulse, 0);
      @(negedge clk);
      #1 chk(!err_pulse && bus_as, "R8 sync delay 2", {err_pulse, bus_as}, 2'b01);
      @(negedge clk);
      sync_term = 1; cache_inhibit = 1;
      #1 chk(err_pulse && !line_drop && !word_we, "R8 error wins", {err_pulse, line_drop, word_we}, 3'b100);
      @(negedge clk);
      bus_err_in = 0; sync_term = 0; cache_inhibit = 0;
      #1 chk(!err_pulse && !bus_as, "R8 one pulse", {err_pulse, bus_as}, 0);
      repeat (4) @(negedge clk);
    end

    halt_in = 1;
    do_fill(32'h0000_0100, 3'b001, 4, 0);
    chk(halted && !bus_grant, "R10 halt after burst", {halted, bus_grant}, 2'b10);
    miss_req = 1;
    @(negedge clk);
    #1 chk(!bus_as && halted, "R10 no miss while halted", {bus_as, halted}, 2'b01);
    miss_req = 0; halt_in = 0;
    repeat (4) @(negedge clk);
    #1 chk(!halted, "R10 released", halted, 0);

    breq_in = 1;
    do_fill(32'h0000_0200, 3'b001, 4, 1);
    chk(bus_grant && !bus_as, "R11 grant after burst", {bus_grant, bus_as}, 2'b10);
    miss_req = 1;
    @(negedge clk);
    #1 chk(!bus_as && bus_grant, "R11 no miss while granted", {bus_as, bus_grant}, 2'b01);
    miss_req = 0; breq_in = 0;
    repeat (4) @(negedge clk);
    #1 chk(!bus_grant, "R11 released", bus_grant, 0);

    halt_in = 1; breq_in = 1;
    do_fill(32'h0000_030C, 3'b001, 4, 0);
    chk(halted && !bus_grant, "R10 R11 halt wins", {halted, bus_grant}, 2'b10);
    halt_in = 0;
    repeat (5) @(negedge clk);
    #1 chk(!halted && bus_grant, "R11 grant after halt", {halted, bus_grant}, 2'b01);
    breq_in = 0;
    repeat (5) @(negedge clk);
    #1 chk(!bus_grant && !halted, "R11 idle again", {halted, bus_grant}, 0);

    breq_in = 1;
    repeat (4) @(negedge clk);
    #1 chk(bus_grant, "R11 grant from idle", bus_grant, 1);
    breq_in = 0;
    repeat (4) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule